// File: doc/BRIEF.md
# SPI Flash Command Protection Controller

This block is the command front end of a serial flash device, seen from the SPI side. It takes chip select, serial clock and serial data in from a host and returns serial data out. The serial pins are brought into the system clock domain through synchronisers. The block decodes one opcode per selection and keeps two status flags: a write-in-progress flag and a write-enable latch. It also reports the device power mode. Commands that change stored data do not touch a storage array. Each accepted one starts an internal busy period whose length is a parameter in system clocks. This lets firmware exercise its enable, poll and power-down sequences against real protection rules.

A command takes effect when chip select rises, and only if the number of serial clock rising edges in that selection is a whole number of bytes. Data-changing commands are gated three ways: the write-enable latch must be set, no busy period may be running, and the device must not be in deep power-down. Deep power-down shuts out every opcode except release. The read-status opcode streams the status byte again and again while chip select stays low, so one long transfer can watch the busy flag drop.

The control state machine has four states. IDLE waits for selection. OPCODE collects the first byte. STREAM returns status bytes. HOLD absorbs any further bytes until deselect. Its transitions are:
- IDLE to OPCODE on chip-select fall.
- OPCODE to STREAM when a complete read-status opcode arrives outside deep power-down.
- OPCODE to HOLD when any other complete opcode arrives.
- OPCODE, STREAM or HOLD back to IDLE on chip-select rise. Leaving HOLD this way is the commit point for the opcode.

Top module: `spi_flash_guard`

## Requirements
- R1: While `rst_n` is low, the write-enable latch, write-in-progress and deep power-down are all cleared and `miso` is 0. After reset, a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch when committed outside deep power-down with no busy period running.
- R3: Opcode 0x04 clears the write-enable latch under the same conditions as R2.
- R4: The data-changing opcodes are 0x02 (page program), 0x0A (page write) and 0xD8 (sector erase). One of these starts a busy period, setting write-in-progress, only if the write-enable latch is set when it commits.
- R5: Any command is discarded unless the count of serial clock rising edges during its selection is a multiple of 8 (and at least 8).
- R6: Write-in-progress stays set for exactly BUSY_CYCLES system clocks. The write-enable latch clears in the clock where the busy period ends. This applies to all three data-changing opcodes.
- R7: A data-changing opcode committed while write-in-progress is set is ignored. It neither restarts nor extends the busy period.
- R8: Opcode 0xB9 enters deep power-down, provided no busy period is running. While in deep power-down, every opcode except 0xAB is ignored, a status read returns 0 bits, and the write-enable latch keeps its value. Opcode 0xAB leaves deep power-down.
- R9: `pwr_mode` reads 2 in deep power-down. Outside deep power-down it reads 1 (active) while chip select is low or write-in-progress is set, and 0 (standby) otherwise.
- R10: After opcode 0x05, the status byte is sent repeatedly for as long as chip select stays low. Each byte reflects the live flags: bit 0 is write-in-progress, bit 1 is the write-enable latch, and the other bits are 0.
- R11: The serial timing is SPI mode 0. `mosi` is sampled on serial clock rising edges and `miso` changes on falling edges, most significant bit first in both directions. An opcode sent in the reverse bit order is not recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 when not streaming |
| pwr_mode | output | 2 | 0 standby, 1 active, 2 deep power-down |

## Verification
The bench sends a data-changing opcode that ends four bits into its second byte. A design that counts only complete bytes, or that commits on the opcode byte alone, would start a busy period from that torn frame. It sends a second program command in the middle of a busy period and later reads status at a time past the first period's end. A design that restarts the timer still reports busy at that point. It sends program and status reads in deep power-down, then releases. A design with a leaky gate shows write-in-progress afterwards or loses the latch. One long status read must show the busy flag fall inside a single selection; a design that latches the status byte once per frame would miss it.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'd0,
        PM_ACTIVE  = 2'd1,
        PM_DEEP    = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_OPCODE,
        FS_STREAM,
        FS_HOLD
    } fsm_e;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_PPROG = 8'h02;
    localparam logic [7:0] OPC_PWRT  = 8'h0A;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_SLEEP = 8'hB9;
    localparam logic [7:0] OPC_WAKE  = 8'hAB;

endpackage

// File: rtl/sg_edge_sync.sv
module sg_edge_sync #(
    parameter int              N      = 3,
    parameter int              STAGES = 2,
    parameter logic [N-1:0]    INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_chan
        logic [STAGES:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {(STAGES+1){INIT[g]}};
            else        pipe <= {pipe[STAGES-1:0], async_in[g]};
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end

endmodule

// File: rtl/sg_serial_port.sv
module sg_serial_port #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              whole_bytes,
    output logic              miso
);

    localparam int              IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W - 1);

    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  tx_idx;
    logic [BYTE_W-2:0] rx_shift;

    assign rx_byte     = {rx_shift, mosi_s};
    assign byte_done   = sck_rise && (bit_idx == LAST);
    assign whole_bytes = (bit_idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            rx_shift <= '0;
        end else if (frame_start) begin
            bit_idx  <= '0;
        end else if (sck_rise) begin
            bit_idx  <= (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
            rx_shift <= rx_byte[BYTE_W-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_idx <= '0;
            miso   <= 1'b0;
        end else if (!tx_en || frame_start) begin
            tx_idx <= '0;
            miso   <= 1'b0;
        end else if (sck_fall) begin
            miso   <= tx_byte[LAST - tx_idx];
            tx_idx <= (tx_idx == LAST) ? '0 : tx_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sg_busy_timer.sv
module sg_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int TMR_W = $clog2(CYCLES + 1);

    logic [TMR_W-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= TMR_W'(CYCLES - 1);
        end
    end

endmodule

// File: rtl/spi_flash_guard.sv
module spi_flash_guard
    import spi_guard_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic [1:0] pwr_mode
);

    localparam int CH_CS = 2, CH_SCK = 1, CH_MOSI = 0;

    logic [2:0] s_lvl, s_rise, s_fall;
    logic       cs_sel, cs_start, cs_end;
    logic [BYTE_W-1:0] rx_byte, status_byte;
    logic       byte_done, whole_bytes;
    logic       wip_q, tmr_done, start_busy;
    logic       wel_q, dpd_q;
    logic [7:0] opcode_q;
    fsm_e       state_q, state_d;
    logic       commit, is_modify, open_gate;

    sg_edge_sync #(.N(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({cs_n, sck, mosi}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    assign cs_sel   = ~s_lvl[CH_CS];
    assign cs_start = s_fall[CH_CS];
    assign cs_end   = s_rise[CH_CS];

    always_comb begin
        status_byte    = '0;
        status_byte[0] = wip_q;
        status_byte[1] = wel_q;
    end

    sg_serial_port #(.BYTE_W(BYTE_W)) u_port (
        .clk(clk), .rst_n(rst_n), .frame_start(cs_start),
        .sck_rise(s_rise[CH_SCK]), .sck_fall(s_fall[CH_SCK]),
        .mosi_s(s_lvl[CH_MOSI]), .tx_en(state_q == FS_STREAM),
        .tx_byte(status_byte), .rx_byte(rx_byte), .byte_done(byte_done),
        .whole_bytes(whole_bytes), .miso(miso)
    );

    sg_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_busy),
        .busy(wip_q), .done(tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:   if (cs_start) state_d = FS_OPCODE;
            FS_OPCODE: begin
                if (cs_end)         state_d = FS_IDLE;
                else if (byte_done) state_d = (rx_byte[7:0] == OPC_RDSR && !dpd_q)
                                              ? FS_STREAM : FS_HOLD;
            end
            FS_STREAM: if (cs_end) state_d = FS_IDLE;
            FS_HOLD:   if (cs_end) state_d = FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   opcode_q <= '0;
        else if (state_q == FS_OPCODE && byte_done)   opcode_q <= rx_byte[7:0];
    end

    // decode at commit
    assign commit    = (state_q == FS_HOLD) && cs_end && whole_bytes;
    assign open_gate = commit && !dpd_q && !wip_q;
    assign is_modify = (opcode_q == OPC_PPROG) || (opcode_q == OPC_PWRT) ||
                       (opcode_q == OPC_SERASE);
    assign start_busy = open_gate && wel_q && is_modify;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
            dpd_q <= 1'b0;
        end else begin
            if (tmr_done)                                  wel_q <= 1'b0;
            else if (open_gate && opcode_q == OPC_WREN)    wel_q <= 1'b1;
            else if (open_gate && opcode_q == OPC_WRDI)    wel_q <= 1'b0;

            if (open_gate && opcode_q == OPC_SLEEP)             dpd_q <= 1'b1;
            else if (commit && dpd_q && opcode_q == OPC_WAKE)   dpd_q <= 1'b0;
        end
    end

    // output process
    always_comb begin
        if (dpd_q)                 pwr_mode = PM_DEEP;
        else if (cs_sel || wip_q)  pwr_mode = PM_ACTIVE;
        else                       pwr_mode = PM_STANDBY;
    end

endmodule

// File: rtl/spi_flash_guard_chk.sv
module spi_flash_guard_chk #(
    parameter int BUSY_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wel,
    input logic       wip,
    input logic       dpd,
    input logic       cs_sel,
    input logic [1:0] pwr_mode
);

    localparam int LEN_W = $clog2(BUSY_CYCLES + 2);
    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_len <= '0;
        else if (wip) run_len <= run_len + 1'b1;
        else          run_len <= '0;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (!wel && !wip && !dpd));

    p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (run_len == LEN_W'(BUSY_CYCLES)));

    p_done_clears_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    p_no_start_in_deep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !$past(dpd));

    p_sel_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sel && !dpd) |-> (pwr_mode == 2'd1));

endmodule

bind spi_flash_guard spi_flash_guard_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wel(wel_q), .wip(wip_q), .dpd(dpd_q),
    .cs_sel(cs_sel), .pwr_mode(pwr_mode)
);

// File: tb/spi_flash_guard_tb.sv
module spi_flash_guard_tb;

    localparam int BUSY = 600;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [1:0] pwr_mode;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] rx [0:7];

    always #2 clk = ~clk;

    spi_flash_guard #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .pwr_mode(pwr_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] op, input int nbits);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? op[7-i] : 1'b0;
            idle(HALF);
            if (i >= 8 && i < 72) rx[(i-8)/8][7-((i-8)%8)] = miso;
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(2*HALF);
    endtask

    task automatic read_status(input int nbytes);
        for (int k = 0; k < 8; k++) rx[k] = 8'hXX;
        frame(8'h05, 8 + 8*nbytes);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(4);
        chk(miso == 1'b0, "R1 miso in reset", miso, 0);
        rst_n = 1'b1;
        idle(4);
    endtask

    task automatic t_reset;
        do_reset();
        chk(pwr_mode == 2'd0, "R9 standby after reset", pwr_mode, 0);
        read_status(1);
        chk(rx[0] == 8'h00, "R1 status after reset", rx[0], 8'h00);
    endtask

    task automatic t_enable;
        frame(8'h06, 8);
        read_status(3);
        chk(rx[0] == 8'h02, "R2 latch set", rx[0], 8'h02);
        chk(rx[1] == 8'h02 && rx[2] == 8'h02, "R10 repeated status", {rx[1], rx[2]}, 16'h0202);
        frame(8'h04, 8);
        read_status(1);
        chk(rx[0] == 8'h00, "R3 latch cleared", rx[0], 8'h00);
    endtask

    task automatic t_gating;
        frame(8'h02, 8);
        read_status(1);
        chk(rx[0] == 8'h00, "R4 program without latch", rx[0], 8'h00);
        frame(8'h06, 9);
        read_status(1);
        chk(rx[0] == 8'h00, "R5 torn enable discarded", rx[0], 8'h00);
        frame(8'h06, 8);
        frame(8'h02, 12);
        read_status(1);
        chk(rx[0] == 8'h02, "R5 torn program discarded", rx[0], 8'h02);
        frame(8'h60, 8);
        frame(8'h04, 8);
        frame(8'h60, 8);
        read_status(1);
        chk(rx[0] == 8'h00, "R11 reversed opcode ignored", rx[0], 8'h00);
    endtask

    task automatic t_busy;
        frame(8'h06, 8);
        frame(8'h0A, 8);
        read_status(1);
        chk(rx[0] == 8'h03, "R4 busy started", rx[0], 8'h03);
        chk(pwr_mode == 2'd1, "R9 active while busy", pwr_mode, 1);
        frame(8'h02, 8);
        idle(300);
        read_status(1);
        chk(rx[0] == 8'h00, "R7 second program did not extend busy", rx[0], 8'h00);
        chk(pwr_mode == 2'd0, "R9 standby after busy", pwr_mode, 0);
    endtask

    task automatic t_poll;
        frame(8'h06, 8);
        frame(8'h02, 8);
        read_status(6);
        chk(rx[0] == 8'h03, "R10 first polled byte", rx[0], 8'h03);
        chk(rx[5] == 8'h00, "R6 busy ended within one poll", rx[5], 8'h00);
    endtask

    task automatic t_erase;
        frame(8'h06, 8);
        frame(8'hD8, 32);
        read_status(1);
        chk(rx[0] == 8'h03, "R4 erase started", rx[0], 8'h03);
        idle(700);
        read_status(1);
        chk(rx[0] == 8'h00, "R6 erase end clears latch", rx[0], 8'h00);
    endtask

    task automatic t_deep;
        frame(8'h06, 8);
        frame(8'hB9, 8);
        chk(pwr_mode == 2'd2, "R8 deep entered", pwr_mode, 2);
        cs_n = 1'b0;
        idle(6);
        chk(pwr_mode == 2'd2, "R9 deep while selected", pwr_mode, 2);
        cs_n = 1'b1;
        idle(6);
        frame(8'h02, 8);
        frame(8'h04, 8);
        read_status(1);
        chk(rx[0] == 8'h00, "R8 no status in deep", rx[0], 8'h00);
        frame(8'hAB, 8);
        chk(pwr_mode == 2'd0, "R8 released to standby", pwr_mode, 0);
        read_status(1);
        chk(rx[0] == 8'h02, "R8 commands ignored in deep", rx[0], 8'h02);
        cs_n = 1'b0;
        idle(6);
        chk(pwr_mode == 2'd1, "R9 active when selected", pwr_mode, 1);
        cs_n = 1'b1;
        idle(6);
    endtask

    task automatic t_reset_mid;
        do_reset();
        read_status(1);
        chk(rx[0] == 8'h00, "R1 reset clears latch", rx[0], 8'h00);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_enable();
        t_gating();
        t_busy();
        t_poll();
        t_erase();
        t_deep();
        t_reset_mid();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            summary();
        end
    end

endmodule